// File: doc/BRIEF.md
# Layered Raster Compositor

This block scans a 640x480 raster from a 27 MHz pixel clock and produces the horizontal sync, vertical sync and composite blank that a monitor needs, together with the coordinates of the pixel being scanned. At each of those coordinates it picks one colour from three layers. The layers are a video window, a full-screen picture and an on-screen menu strip. The sources answer combinationally with the colour for the coordinate on `pix_x`/`pix_y`.

The video layer covers a 120x96 window whose top-left corner software places with two offset inputs. The picture layer marks each pixel it covers with a present flag. A mode input decides which of those two layers sits on top of the other. The menu is a 207x32 strip of 1-bit-per-channel colour at a fixed origin. When it is enabled and its present flag is set, it covers both other layers. Narrow source colours are widened to 8 bits per channel by repeating their upper bits. Wherever no layer is present the pixel is black.

Top module: `disp_compositor`

## Requirements
- R1: The column counter `pix_x` counts 0 to H_ACT+H_FP+H_SYNC+H_BP-1 (799 by default), advances every clock and then returns to 0. Reset sets both counters to 0.
- R2: `hsync_n` is low for exactly the columns H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1 (659 to 754) and high elsewhere. Each line holds the active region, then the front porch, then sync, then the back porch.
- R3: `pix_y` advances only when `pix_x` wraps, and it wraps after V_ACT+V_FP+V_SYNC+V_BP lines (525). `vsync_n` is low for the rows V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1 (493 and 494).
- R4: `blank_n` is high exactly when `pix_x` < H_ACT and `pix_y` < V_ACT.
- R5: `rgb_out` is zero whenever `blank_n` is low.
- R6: With `pic_on_top`=1, a visible pixel shows the picture when `pic_present` is 1. Otherwise it shows the video if the video window covers the pixel, and otherwise black.
- R7: With `pic_on_top`=0, a visible pixel shows the video when the video window covers it. Otherwise it shows the picture if `pic_present` is 1, and otherwise black.
- R8: When `menu_en`=1, `menu_present`=1 and the pixel lies in the MENU_W x MENU_H area whose corner is at (MENU_X0, MENU_Y0), the menu colour replaces the result of R6 or R7. With `menu_en`=0 the menu inputs have no effect on `rgb_out`.
- R9: The video counts as present only when `vid_x_off` <= `pix_x` < `vid_x_off`+VID_W and `vid_y_off` <= `pix_y` < `vid_y_off`+VID_H (VID_W=120, VID_H=96).
- R10: `rgb_out` is {R,G,B}, with R in bits 23:16 and B in bits 7:0. Video input is R[17:12], G[11:6], B[5:0], and each 6-bit channel c becomes {c, c[5:4]}. Picture input is R[14:10], G[9:5], B[4:0], and each 5-bit channel p becomes {p, p[4:2]}. Menu bit 2 is R, bit 1 is G and bit 0 is B, and each bit becomes 8'hFF when set and 8'h00 when clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_rgb | input | 18 | Video colour for the current pixel, 6 bits per channel |
| vid_x_off | input | XW (10) | Video window left column |
| vid_y_off | input | YW (10) | Video window top row |
| pic_rgb | input | 15 | Picture colour, 5 bits per channel |
| pic_present | input | 1 | Picture covers the current pixel |
| pic_on_top | input | 1 | 1: picture above video, 0: video above picture |
| menu_rgb | input | 3 | Menu colour, 1 bit per channel |
| menu_present | input | 1 | Menu data exists at the current pixel |
| menu_en | input | 1 | Menu overlay switched on |
| pix_x | output | XW (10) | Current column |
| pix_y | output | YW (10) | Current row |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | High on visible pixels |
| rgb_out | output | 24 | Composited colour |

## Verification
The assertions assume that reset is held for at least one clock edge. They assume nothing else about the layer inputs, because the timing outputs do not depend on them, and the blanking rule must hold for any colour that arrives. The stimulus draws every layer input and flag anew each cycle. It keeps the offsets inside the line and frame widths, so the video window falls at least partly on the screen. A second instance with a very small raster carries the bench through many complete frames. That is how the vertical sync and the frame wrap are reached within the cycle budget.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb24_t;

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen1(input logic c);
    return {8{c}};
  endfunction

  // half-open span test: start <= pos < start + len
  function automatic logic in_span(input int pos, input int start, input int len);
    return (pos >= start) && (pos < start + len);
  endfunction

endpackage

// File: rtl/scan_axis.sv
module scan_axis #(
  parameter int ACT  = 640,
  parameter int FP   = 19,
  parameter int SYNC = 96,
  parameter int BP   = 45,
  localparam int TOTAL = ACT + FP + SYNC + BP,
  localparam int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] pos,
  output logic         active,
  output logic         sync_n,
  output logic         wrap
);

  localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
  localparam logic [W-1:0] ACT_END = W'(ACT);
  localparam logic [W-1:0] SY_BEG  = W'(ACT + FP);
  localparam logic [W-1:0] SY_END  = W'(ACT + FP + SYNC);

  assign wrap   = step && (pos == LAST);
  assign active = pos < ACT_END;
  assign sync_n = !((pos >= SY_BEG) && (pos < SY_END));

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (wrap)    pos <= '0;
    else if (step)    pos <= pos + 1'b1;
  end

endmodule

// File: rtl/layer_merge.sv
module layer_merge
  import disp_pkg::*;
#(
  parameter int XW      = 10,
  parameter int YW      = 10,
  parameter int VID_W   = 120,
  parameter int VID_H   = 96,
  parameter int MENU_X0 = 400,
  parameter int MENU_Y0 = 0,
  parameter int MENU_W  = 207,
  parameter int MENU_H  = 32
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [XW-1:0] vid_x_off,
  input  logic [YW-1:0] vid_y_off,
  input  logic [17:0]   vid_rgb,
  input  logic [14:0]   pic_rgb,
  input  logic          pic_present,
  input  logic          pic_on_top,
  input  logic [2:0]    menu_rgb,
  input  logic          menu_present,
  input  logic          menu_en,
  output logic          vid_hit,
  output logic          menu_hit,
  output rgb24_t        pix
);

  rgb24_t vid_c, pic_c, menu_c, under;

  assign vid_hit  = in_span(int'(x), int'(vid_x_off), VID_W) &&
                    in_span(int'(y), int'(vid_y_off), VID_H);
  assign menu_hit = menu_en && menu_present &&
                    in_span(int'(x), MENU_X0, MENU_W) &&
                    in_span(int'(y), MENU_Y0, MENU_H);

  assign vid_c  = '{r: widen6(vid_rgb[17:12]), g: widen6(vid_rgb[11:6]), b: widen6(vid_rgb[5:0])};
  assign pic_c  = '{r: widen5(pic_rgb[14:10]), g: widen5(pic_rgb[9:5]), b: widen5(pic_rgb[4:0])};
  assign menu_c = '{r: widen1(menu_rgb[2]), g: widen1(menu_rgb[1]), b: widen1(menu_rgb[0])};

  always_comb begin
    under = '0;
    if (pic_on_top) begin
      if (pic_present)  under = pic_c;
      else if (vid_hit) under = vid_c;
    end else begin
      if (vid_hit)          under = vid_c;
      else if (pic_present) under = pic_c;
    end
    pix = menu_hit ? menu_c : under;
  end

endmodule

// File: rtl/disp_compositor.sv
module disp_compositor
  import disp_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int H_FP    = 19,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 45,
  parameter int V_ACT   = 480,
  parameter int V_FP    = 13,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 30,
  parameter int VID_W   = 120,
  parameter int VID_H   = 96,
  parameter int MENU_X0 = 400,
  parameter int MENU_Y0 = 0,
  parameter int MENU_W  = 207,
  parameter int MENU_H  = 32,
  localparam int XW = $clog2(H_ACT + H_FP + H_SYNC + H_BP),
  localparam int YW = $clog2(V_ACT + V_FP + V_SYNC + V_BP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [17:0]   vid_rgb,
  input  logic [XW-1:0] vid_x_off,
  input  logic [YW-1:0] vid_y_off,
  input  logic [14:0]   pic_rgb,
  input  logic          pic_present,
  input  logic          pic_on_top,
  input  logic [2:0]    menu_rgb,
  input  logic          menu_present,
  input  logic          menu_en,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank_n,
  output logic [23:0]   rgb_out
);

  // named internal events, observed by the bound checker
  logic   h_active, v_active, line_end, frame_end;
  logic   vid_hit, menu_hit;
  rgb24_t merged;

  scan_axis #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_h (
    .clk(clk), .rst_n(rst_n), .step(1'b1),
    .pos(pix_x), .active(h_active), .sync_n(hsync_n), .wrap(line_end)
  );

  scan_axis #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_v (
    .clk(clk), .rst_n(rst_n), .step(line_end),
    .pos(pix_y), .active(v_active), .sync_n(vsync_n), .wrap(frame_end)
  );

  layer_merge #(
    .XW(XW), .YW(YW), .VID_W(VID_W), .VID_H(VID_H),
    .MENU_X0(MENU_X0), .MENU_Y0(MENU_Y0), .MENU_W(MENU_W), .MENU_H(MENU_H)
  ) u_merge (
    .x(pix_x), .y(pix_y), .vid_x_off(vid_x_off), .vid_y_off(vid_y_off),
    .vid_rgb(vid_rgb), .pic_rgb(pic_rgb), .pic_present(pic_present),
    .pic_on_top(pic_on_top), .menu_rgb(menu_rgb), .menu_present(menu_present),
    .menu_en(menu_en), .vid_hit(vid_hit), .menu_hit(menu_hit), .pix(merged)
  );

  assign blank_n = h_active && v_active;
  assign rgb_out = blank_n ? merged : 24'h0;

endmodule

// File: rtl/disp_compositor_chk.sv
module disp_compositor_chk #(
  parameter int H_ACT = 640, parameter int H_FP = 19, parameter int H_SYNC = 96, parameter int H_BP = 45,
  parameter int V_ACT = 480, parameter int V_FP = 13, parameter int V_SYNC = 2, parameter int V_BP = 30,
  parameter int XW = 10, parameter int YW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          blank_n,
  input logic [23:0]   rgb_out,
  input logic          line_end,
  input logic          frame_end
);

  localparam logic [XW-1:0] X_LAST = XW'(H_ACT + H_FP + H_SYNC + H_BP - 1);
  localparam logic [XW-1:0] HS_BEG = XW'(H_ACT + H_FP);
  localparam logic [XW-1:0] HS_END = XW'(H_ACT + H_FP + H_SYNC);
  localparam logic [YW-1:0] VS_BEG = YW'(V_ACT + V_FP);

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != X_LAST) |=> (pix_x == $past(pix_x) + 1'b1)); // R1
  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == X_LAST) |=> (pix_x == '0)); // R1
  AST_HS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (pix_x == HS_BEG)); // R2
  AST_HS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> (pix_x == HS_END)); // R2
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(pix_y)); // R3
  AST_VS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (pix_y == VS_BEG && pix_x == '0)); // R3
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pix_x == '0 && pix_y == '0)); // R3
  AST_BLANK_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    blank_n |-> (pix_x < XW'(H_ACT) && pix_y < YW'(V_ACT))); // R4
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (rgb_out == 24'h0)); // R5

endmodule

bind disp_compositor disp_compositor_chk #(
  .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .XW(XW), .YW(YW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n), .rgb_out(rgb_out),
  .line_end(line_end), .frame_end(frame_end)
);

// File: tb/test_disp_compositor.sv
module test_disp_compositor;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 2400;

  // small raster for the second instance
  localparam int SHA = 16, SHF = 2, SHS = 3, SHB = 4;
  localparam int SVA = 6,  SVF = 1, SVS = 2, SVB = 1;

  logic clk = 0, rst_n = 0;
  logic [17:0] vid_rgb = 0;
  logic [9:0]  xo = 0, yo = 0;
  logic [4:0]  sxo = 0;
  logic [3:0]  syo = 0;
  logic [14:0] pic_rgb = 0;
  logic pic_present = 0, pic_on_top = 0, menu_present = 0, menu_en = 0;
  logic [2:0] menu_rgb = 0;

  logic [9:0] px, py;
  logic hs, vs, bl;
  logic [23:0] rgb;
  logic [4:0] spx;
  logic [3:0] spy;
  logic shs, svs, sbl;
  logic [23:0] srgb;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_compositor i_disp_compositor (
    .clk(clk), .rst_n(rst_n), .vid_rgb(vid_rgb), .vid_x_off(xo), .vid_y_off(yo),
    .pic_rgb(pic_rgb), .pic_present(pic_present), .pic_on_top(pic_on_top),
    .menu_rgb(menu_rgb), .menu_present(menu_present), .menu_en(menu_en),
    .pix_x(px), .pix_y(py), .hsync_n(hs), .vsync_n(vs), .blank_n(bl), .rgb_out(rgb)
  );

  disp_compositor #(
    .H_ACT(SHA), .H_FP(SHF), .H_SYNC(SHS), .H_BP(SHB),
    .V_ACT(SVA), .V_FP(SVF), .V_SYNC(SVS), .V_BP(SVB),
    .VID_W(5), .VID_H(3), .MENU_X0(2), .MENU_Y0(1), .MENU_W(4), .MENU_H(2)
  ) i_disp_compositor_small (
    .clk(clk), .rst_n(rst_n), .vid_rgb(vid_rgb), .vid_x_off(sxo), .vid_y_off(syo),
    .pic_rgb(pic_rgb), .pic_present(pic_present), .pic_on_top(pic_on_top),
    .menu_rgb(menu_rgb), .menu_present(menu_present), .menu_en(menu_en),
    .pix_x(spx), .pix_y(spy), .hsync_n(shs), .vsync_n(svs), .blank_n(sbl), .rgb_out(srgb)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at t=%0t: actual %h expected %h", what, $time, got, exp);
    end
  endtask

  // widening by shifts, R10
  function automatic logic [7:0] up6(input logic [5:0] c);
    return 8'((int'(c) << 2) | (int'(c) >> 4));
  endfunction
  function automatic logic [7:0] up5(input logic [4:0] c);
    return 8'((int'(c) << 3) | (int'(c) >> 2));
  endfunction

  function automatic logic low_in(input int p, input int a, input int f, input int s);
    return (p >= a + f) && (p < a + f + s);
  endfunction

  // expected colour and the requirement it exercises
  function automatic logic [23:0] want_rgb(
    input int x, input int y, input int ha, input int va, input int ox, input int oy,
    input int vw, input int vh, input int mx, input int my, input int mw, input int mh,
    output string tag);
    logic [23:0] v, p, m, u;
    logic vin, mhit;
    v = {up6(vid_rgb[17:12]), up6(vid_rgb[11:6]), up6(vid_rgb[5:0])};
    p = {up5(pic_rgb[14:10]), up5(pic_rgb[9:5]), up5(pic_rgb[4:0])};
    m = {{8{menu_rgb[2]}}, {8{menu_rgb[1]}}, {8{menu_rgb[0]}}};
    vin  = x >= ox && x < ox + vw && y >= oy && y < oy + vh;
    mhit = menu_en && menu_present && x >= mx && x < mx + mw && y >= my && y < my + mh;
    if (pic_on_top) u = pic_present ? p : (vin ? v : 24'h0);
    else            u = vin ? v : (pic_present ? p : 24'h0);
    if (!(x < ha && y < va)) begin tag = "R5 blank black"; return 24'h0; end
    if (mhit) begin tag = "R8 R10 menu on top"; return m; end
    if (menu_en == 0 && menu_present) tag = "R8 disabled menu ignored";
    else if (pic_on_top) tag = "R6 R9 R10 picture over video";
    else tag = "R7 R9 R10 video over picture";
    return u;
  endfunction

  int mx, my, sx, sy;

  task automatic check_all();
    string t;
    logic [23:0] e;
    chk("R1 column", 32'(px), 32'(mx));
    chk("R3 row", 32'(py), 32'(my));
    chk("R2 hsync", 32'(hs), 32'(!low_in(mx, 640, 19, 96)));
    chk("R3 vsync", 32'(vs), 32'(!low_in(my, 480, 13, 2)));
    chk("R4 blank", 32'(bl), 32'(mx < 640 && my < 480));
    e = want_rgb(mx, my, 640, 480, int'(xo), int'(yo), 120, 96, 400, 0, 207, 32, t);
    chk({t, " (full)"}, 32'(rgb), 32'(e));
    chk("R1 small column", 32'(spx), 32'(sx));
    chk("R3 small row", 32'(spy), 32'(sy));
    chk("R2 small hsync", 32'(shs), 32'(!low_in(sx, SHA, SHF, SHS)));
    chk("R3 small vsync", 32'(svs), 32'(!low_in(sy, SVA, SVF, SVS)));
    chk("R4 small blank", 32'(sbl), 32'(sx < SHA && sy < SVA));
    e = want_rgb(sx, sy, SHA, SVA, int'(sxo), int'(syo), 5, 3, 2, 1, 4, 2, t);
    chk({t, " (small)"}, 32'(srgb), 32'(e));
  endtask

  task automatic advance();
    mx = (mx == 799) ? 0 : mx + 1;
    if (mx == 0) my = (my == 524) ? 0 : my + 1;
    sx = (sx == SHA+SHF+SHS+SHB-1) ? 0 : sx + 1;
    if (sx == 0) sy = (sy == SVA+SVF+SVS+SVB-1) ? 0 : sy + 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mx = 0; my = 0; sx = 0; sy = 0;
    repeat (4) @(negedge clk);
    #1;
    // R1 R3: reset holds both counters at the origin
    chk("R1 reset column", 32'(px), 32'd0);
    chk("R3 reset row", 32'(py), 32'd0);
    chk("R4 reset blank", 32'(bl), 32'd1);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      vid_rgb      = 18'($urandom);
      pic_rgb      = 15'($urandom);
      menu_rgb     = 3'($urandom);
      pic_present  = 1'($urandom);
      menu_present = 1'($urandom);
      menu_en      = 1'($urandom);
      if (c % 200 == 0) pic_on_top = ~pic_on_top;
      if (c % 150 == 0) begin
        xo  = 10'($urandom_range(0, 600));
        yo  = 10'($urandom_range(0, 2));
        sxo = 5'($urandom_range(0, 14));
        syo = 4'($urandom_range(0, 5));
      end
      // directed corner: video window touching the left edge, menu off with data present
      if (c == 1000) begin xo = 0; yo = 0; end
      if (c >= 1000 && c < 1010) begin menu_en = 0; menu_present = 1; end
      #1;
      check_all();
      @(posedge clk);
      advance();
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule